// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Program Counter

This block sequences a small accumulator processor. Every instruction takes exactly eight clocks. A three-bit phase counter records how many clocks of the current instruction have already elapsed. From that phase, the opcode held in the external instruction register, and the accumulator's zero flag, the block drives the strobes for the rest of the machine:

- memory read and write,
- instruction-register load,
- accumulator load,
- accumulator bus drive,
- halt.

It also drives a fetch flag that is high for the first half of every instruction. The block owns the program counter and the address multiplexer. The address output carries the program counter during the fetch half and the instruction's operand address during the execute half. It returns to the program counter in the last phase so the next fetch address is already settled.

A synchronous reset holds everything idle. The sequence starts on the first clock after reset is released, at phase 0, with the fetch flag rising and the program counter at 0. An enable input freezes the sequence in place. The ALU, the memories and any clock division sit outside this block. All pins are plain control and status levels; no stream handshake is involved.

Opcode encoding, on `opcode`:

| Code | Instruction |
|------|-------------|
| 000 | HLT |
| 001 | SKZ |
| 010 | ADD |
| 011 | AND |
| 100 | XOR |
| 101 | LDA |
| 110 | STO |
| 111 | JMP |

Top module: `instr_cycle_ctrl`

## Requirements
- R1: While running, enabled and not halted, `cyc_state` advances by one per clock and wraps from 7 to 0.
- R2: `fetch` is high in phases 0 to 3 and low in phases 4 to 7. `addr` equals `pc` in phases 0 to 3 and in phase 7, and equals `operand` in phases 4 to 6.
- R3: While `rst` is high, all of these hold: `cyc_state` is 0, `pc` is 0, and `fetch`, `rd`, `wr`, `load_ir`, `load_acc`, `datactl_ena` and `halt` are low. On the first clock with `rst` low, the block enters phase 0 with `fetch` rising and `pc` at 0.
- R4: While `ena` is low, `cyc_state` and `pc` hold their values, and `wr`, `load_ir` and `load_acc` are low.
- R5: In phases 1 and 2, for every opcode, `rd` and `load_ir` are high. `pc` increases by 1 at the end of each of those phases.
- R6: For opcodes 010, 011, 100 and 101, `rd` is high in phases 4 to 6 and `load_acc` is high in phase 6 only.
- R7: For opcode 110, `datactl_ena` is high in phases 4 to 6, `wr` is high in phase 5 only, and `rd` is low in phases 4 to 7.
- R8: For opcode 001 with `acc_zero` high, `pc` increases by 1 at the end of phase 5 and again at the end of phase 6, skipping one two-byte instruction. With `acc_zero` low, `pc` is unchanged in those phases.
- R9: For opcode 111, `pc` loads `operand` at the end of phase 6.
- R10: For opcode 000, `halt` goes high in phase 3. The phase then stays at 3 and `halt` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, may be held |
| ena | input | 1 | Sequence enable; low freezes the phase and the program counter |
| opcode | input | 3 | Opcode from the instruction register |
| operand | input | ADDR_W | Operand address from the instruction register |
| acc_zero | input | 1 | Accumulator-is-zero flag |
| fetch | output | 1 | High during the fetch half of the instruction |
| rd | output | 1 | Memory read enable |
| wr | output | 1 | Memory write strobe |
| load_ir | output | 1 | Instruction-register byte load |
| load_acc | output | 1 | Accumulator load |
| datactl_ena | output | 1 | Accumulator drives the data bus |
| halt | output | 1 | Halted indication |
| cyc_state | output | 3 | Clocks elapsed in the current instruction |
| pc | output | ADDR_W | Program counter (byte address) |
| addr | output | ADDR_W | Multiplexed memory address |

## Verification
Checked on every cycle:
- the phase stepping while running,
- the fetch flag rising only at phase 0,
- the program counter and phase freezing while enable is low,
- the quiet outputs while reset is held,
- write strobes falling inside the bus-drive window,
- read and write never overlapping,
- halt persisting once set.

Only the bench's scenarios can show the rest:
- the full per-phase strobe pattern for each of the seven non-halting opcodes, with the zero flag both low and high,
- the program-counter arithmetic across skips and jumps,
- address multiplexing against a moving operand,
- a freeze in the middle of a store,
- halting followed by recovery through reset.

// File: rtl/ctlseq_pkg.sv
package ctlseq_pkg;

  localparam int CYCLE_LEN = 8;
  localparam int STATE_W   = $clog2(CYCLE_LEN);
  localparam int FETCH_LEN = CYCLE_LEN / 2;

  typedef enum logic [2:0] {
    OP_HLT = 3'd0,
    OP_SKZ = 3'd1,
    OP_ADD = 3'd2,
    OP_AND = 3'd3,
    OP_XOR = 3'd4,
    OP_LDA = 3'd5,
    OP_STO = 3'd6,
    OP_JMP = 3'd7
  } op_e;

  typedef struct packed {
    logic fetch;
    logic rd;
    logic wr;
    logic load_ir;
    logic load_acc;
    logic datactl;
    logic halt;
    logic pc_inc;
    logic pc_load;
    logic pc_sel;
  } ctl_t;

  function automatic logic op_reads_mem(op_e op);
    return (op == OP_ADD) || (op == OP_AND) || (op == OP_XOR) || (op == OP_LDA);
  endfunction

endpackage

// File: rtl/cyc_counter.sv
module cyc_counter
  import ctlseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ena,
  input  logic               hold,
  output logic               running,
  output logic [STATE_W-1:0] state
);

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      state   <= '0;
    end else begin
      running <= 1'b1;
      if (running && ena && !hold) begin
        if (state == STATE_W'(CYCLE_LEN - 1)) state <= '0;
        else                                  state <= state + 1'b1;
      end
    end
  end

endmodule

// File: rtl/step_decode.sv
module step_decode
  import ctlseq_pkg::*;
(
  input  logic               running,
  input  logic               ena,
  input  logic [STATE_W-1:0] state,
  input  op_e                op,
  input  logic               acc_zero,
  output ctl_t               ctl
);

  localparam logic [STATE_W-1:0] S_BYTE_HI = STATE_W'(1);
  localparam logic [STATE_W-1:0] S_BYTE_LO = STATE_W'(2);
  localparam logic [STATE_W-1:0] S_DECODE  = STATE_W'(FETCH_LEN - 1);
  localparam logic [STATE_W-1:0] S_EX0     = STATE_W'(FETCH_LEN);
  localparam logic [STATE_W-1:0] S_EX1     = STATE_W'(FETCH_LEN + 1);
  localparam logic [STATE_W-1:0] S_EX2     = STATE_W'(FETCH_LEN + 2);
  localparam logic [STATE_W-1:0] S_LAST    = STATE_W'(CYCLE_LEN - 1);

  logic in_fetch, byte_ph, exec_win, reads, stores;

  always_comb begin
    in_fetch = (state < STATE_W'(FETCH_LEN));
    byte_ph  = (state == S_BYTE_HI) || (state == S_BYTE_LO);
    exec_win = (state >= S_EX0) && (state <= S_EX2);
    reads    = op_reads_mem(op);
    stores   = (op == OP_STO);

    ctl = '0;
    if (running) begin
      ctl.fetch    = in_fetch;
      ctl.pc_sel   = in_fetch || (state == S_LAST);
      ctl.rd       = byte_ph || (reads && exec_win);
      ctl.load_ir  = byte_ph && ena;
      ctl.load_acc = reads && (state == S_EX2) && ena;
      ctl.datactl  = stores && exec_win;
      ctl.wr       = stores && (state == S_EX1) && ena;
      ctl.halt     = (op == OP_HLT) && (state == S_DECODE);
      ctl.pc_inc   = ena && (byte_ph ||
                     ((op == OP_SKZ) && acc_zero &&
                      ((state == S_EX1) || (state == S_EX2))));
      ctl.pc_load  = ena && (op == OP_JMP) && (state == S_EX2);
    end
  end

endmodule

// File: rtl/prog_counter.sv
module prog_counter #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] pc
);

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (load) pc <= load_val;
    else if (inc)  pc <= pc + 1'b1;
  end

endmodule

// File: rtl/instr_cycle_ctrl.sv
module instr_cycle_ctrl
  import ctlseq_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ena,
  input  logic [2:0]        opcode,
  input  logic [ADDR_W-1:0] operand,
  input  logic              acc_zero,
  output logic              fetch,
  output logic              rd,
  output logic              wr,
  output logic              load_ir,
  output logic              load_acc,
  output logic              datactl_ena,
  output logic              halt,
  output logic [2:0]        cyc_state,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] addr
);

  logic               running;
  logic [STATE_W-1:0] state;
  ctl_t               ctl;

  cyc_counter u_cnt (
    .clk     (clk),
    .rst     (rst),
    .ena     (ena),
    .hold    (ctl.halt),
    .running (running),
    .state   (state)
  );

  step_decode u_dec (
    .running  (running),
    .ena      (ena),
    .state    (state),
    .op       (op_e'(opcode)),
    .acc_zero (acc_zero),
    .ctl      (ctl)
  );

  prog_counter #(.ADDR_W(ADDR_W)) u_pc (
    .clk      (clk),
    .rst      (rst),
    .inc      (ctl.pc_inc),
    .load     (ctl.pc_load),
    .load_val (operand),
    .pc       (pc)
  );

  assign addr        = ctl.pc_sel ? pc : operand;
  assign fetch       = ctl.fetch;
  assign rd          = ctl.rd;
  assign wr          = ctl.wr;
  assign load_ir     = ctl.load_ir;
  assign load_acc    = ctl.load_acc;
  assign datactl_ena = ctl.datactl;
  assign halt        = ctl.halt;
  assign cyc_state   = 3'(state);

endmodule

// File: rtl/instr_cycle_ctrl_chk.sv
module instr_cycle_ctrl_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              ena,
  input logic              running,
  input logic              fetch,
  input logic              rd,
  input logic              wr,
  input logic              load_ir,
  input logic              load_acc,
  input logic              datactl_ena,
  input logic              halt,
  input logic [2:0]        cyc_state,
  input logic [ADDR_W-1:0] pc
);

  p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
    (running && ena && !halt) |=> (cyc_state == 3'($past(cyc_state) + 3'd1)));

  p_fetch_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch) |-> (cyc_state == 3'd0));

  p_reset_quiet_r3: assert property (@(posedge clk)
    rst |=> (pc == '0 && cyc_state == 3'd0 && !fetch && !rd && !wr &&
             !load_ir && !load_acc && !datactl_ena && !halt));

  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    (running && !ena) |=> ($stable(cyc_state) && $stable(pc)));

  p_wr_window_r7: assert property (@(posedge clk) disable iff (rst)
    wr |-> datactl_ena);

  p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(rd && wr));

  p_halt_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    halt |=> (halt && $stable(cyc_state)));

endmodule

bind instr_cycle_ctrl instr_cycle_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ena         (ena),
  .running     (running),
  .fetch       (fetch),
  .rd          (rd),
  .wr          (wr),
  .load_ir     (load_ir),
  .load_acc    (load_acc),
  .datactl_ena (datactl_ena),
  .halt        (halt),
  .cyc_state   (cyc_state),
  .pc          (pc)
);

// File: tb/instr_cycle_ctrl_test.sv
`timescale 1ns/1ps
module instr_cycle_ctrl_test;

  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ena = 1'b1;
  logic [2:0]    opcode = 3'd0;
  logic [AW-1:0] operand = '0;
  logic          acc_zero = 1'b0;
  logic fetch, rd, wr, load_ir, load_acc, datactl_ena, halt;
  logic [2:0]    cyc_state;
  logic [AW-1:0] pc, addr;

  int n_run = 0;
  int n_fail = 0;
  logic [AW-1:0] pc_exp = '0;

  always #2.5 clk = ~clk;

  instr_cycle_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .ena(ena), .opcode(opcode), .operand(operand),
    .acc_zero(acc_zero), .fetch(fetch), .rd(rd), .wr(wr), .load_ir(load_ir),
    .load_acc(load_acc), .datactl_ena(datactl_ena), .halt(halt),
    .cyc_state(cyc_state), .pc(pc), .addr(addr)
  );

  // {fetch, rd, wr, load_ir, load_acc, datactl_ena, halt}
  function automatic logic [6:0] expv(int s, logic [2:0] op);
    logic rdop;
    rdop = (op >= 3'd2) && (op <= 3'd5);
    return {s < 4,
            (s == 1 || s == 2) || (rdop && s >= 4 && s <= 6),
            (op == 3'd6) && s == 5,
            (s == 1 || s == 2),
            rdop && s == 6,
            (op == 3'd6) && s >= 4 && s <= 6,
            (op == 3'd0) && s == 3};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_phase(int s, logic [2:0] op, string req);
    check({req, " phase"}, 32'(cyc_state), 32'(s));
    check({req, " strobes"}, 32'({fetch, rd, wr, load_ir, load_acc, datactl_ena, halt}),
          32'(expv(s, op)));
    check("R2 addr", 32'(addr), 32'((s < 4 || s == 7) ? pc_exp : operand));
    check({req, " pc"}, 32'(pc), 32'(pc_exp));
  endtask

  function automatic logic [AW-1:0] next_pc(int s, logic [2:0] op, logic z,
                                            logic [AW-1:0] p, logic [AW-1:0] opd);
    if (s == 1 || s == 2) return p + 1'b1;
    if (op == 3'd1 && z && (s == 5 || s == 6)) return p + 1'b1;
    if (op == 3'd7 && s == 6) return opd;
    return p;
  endfunction

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R3: held reset is quiet
    check("R3 reset strobes", 32'({fetch, rd, wr, load_ir, load_acc, datactl_ena, halt}), 32'd0);
    check("R3 reset pc", 32'(pc), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R3 start fetch", 32'(fetch), 32'd1);
    check("R3 start phase", 32'(cyc_state), 32'd0);

    // R1 R2 R5 R6 R7 R8 R9: sweep opcodes 1..7 with both zero-flag values
    for (int k = 0; k < 14; k++) begin
      logic [2:0] op;
      op = 3'(1 + k / 2);
      opcode = op;
      acc_zero = k[0];
      operand = AW'(13'h0A5 + k * 313);
      for (int s = 0; s < 8; s++) begin
        check_phase(s, op, (op == 3'd6) ? "R7" : (op >= 3'd2 && op <= 3'd5) ? "R6" :
                           (op == 3'd1) ? "R8" : (op == 3'd7) ? "R9" : "R5");
        pc_exp = next_pc(s, op, acc_zero, pc_exp, operand);
        @(negedge clk);
      end
      check("R1 wrap", 32'(cyc_state), 32'd0);
    end

    // R4: freeze in the middle of a store at phase 5
    opcode = 3'd6;
    operand = 13'h1234;
    for (int s = 0; s < 5; s++) begin
      pc_exp = next_pc(s, 3'd6, 1'b0, pc_exp, operand);
      @(negedge clk);
    end
    ena = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R4 held phase", 32'(cyc_state), 32'd5);
      check("R4 wr low", 32'(wr), 32'd0);
      check("R4 pc held", 32'(pc), 32'(pc_exp));
    end
    ena = 1'b1;
    #0.1;
    check("R7 wr resumes", 32'(wr), 32'd1);
    for (int s = 5; s < 8; s++) begin
      pc_exp = next_pc(s, 3'd6, 1'b0, pc_exp, operand);
      @(negedge clk);
    end
    // R4: freeze in a byte-load phase must not advance pc
    @(negedge clk);
    ena = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 byte phase held", 32'(cyc_state), 32'd1);
    check("R4 load_ir low", 32'(load_ir), 32'd0);
    check("R4 pc no inc", 32'(pc), 32'(pc_exp));
    ena = 1'b1;
    for (int s = 1; s < 8; s++) begin
      pc_exp = next_pc(s, 3'd6, 1'b0, pc_exp, operand);
      @(negedge clk);
    end

    // R10: halt
    opcode = 3'd0;
    for (int s = 0; s < 3; s++) begin
      pc_exp = next_pc(s, 3'd0, 1'b0, pc_exp, operand);
      @(negedge clk);
    end
    check("R10 halt set", 32'(halt), 32'd1);
    repeat (4) @(negedge clk);
    check("R10 halt held", 32'(halt), 32'd1);
    check("R10 phase held", 32'(cyc_state), 32'd3);
    check("R10 pc held", 32'(pc), 32'(pc_exp));

    // R3: reset recovers from halt
    rst = 1'b1;
    @(negedge clk);
    check("R3 reset after halt", 32'({halt, fetch, pc}), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R3 restart", 32'({fetch, cyc_state, pc}), 32'({1'b1, 3'd0, 13'd0}));

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule